// File: doc/BRIEF.md
# Dual-Bank 16-bit Multiply-Accumulate Unit

This block is a 16x16 multiplier feeding a 40-bit accumulator, controlled by one already-decoded command per clock. Each of the two multiplier inputs is a 16-bit half of a 32-bit source. The first input's source is either a general-register value on a port or one of two internal data registers (the A bank). The second input's source is either another general-register value or one of two further data registers (the B bank). Each input has its own bit that chooses the upper or the lower half of its source.

A command performs one of four actions: it multiplies and replaces the accumulator, it multiplies and adds, it multiplies and subtracts, or it does no arithmetic. The same command can also load one of the four data registers with a 32-bit word read from memory. For that load the block computes the access address: the base address plus or minus four bytes, with the step applied before the access. That same address is the value to write back to the base register. When a load and a multiply share a command, the multiply sees the data registers as they were before the load, so a filter loop can reload operands while it keeps accumulating.

Top module: `mac16_unit`

## Requirements
- R1: The accumulator is 40 bits wide. A synchronous active-high reset clears it and all four data registers. It is presented as `acc_lo` (bits 31:0) and `acc_hi` (bits 39:32).
- R2: Each operand is the upper 16 bits of its 32-bit source when its half-select bit is 1, and the lower 16 bits when that bit is 0. The two operands select their halves independently.
- R3: Operand A comes from `gr_a` when `a_from_dreg`=0, and otherwise from data register 0 (`a_dsel`=0) or 1 (`a_dsel`=1). Operand B comes from `gr_b` when `b_from_dreg`=0, and otherwise from data register 2 (`b_dsel`=0) or 3 (`b_dsel`=1).
- R4: `cmd_kind`=0 (multiply) replaces the accumulator with the product, which is sign-extended to 40 bits when the product is signed.
- R5: `cmd_unsigned`=1 makes the product unsigned (zero-extended) only for `cmd_kind`=0 when both operands come from the general-register inputs. For any other combination the bit is ignored and the product is signed.
- R6: `cmd_kind`=1 adds the signed product to the accumulator. `cmd_kind`=2 subtracts it.
- R7: Accumulator arithmetic wraps modulo 2^40 and does not saturate.
- R8: With `ld_en`=1, data register `ld_idx` takes `mem_rdata` at the sampling edge. `ld_addr` is `addr_base`+4 when `ld_down`=0 and `addr_base`-4 when `ld_down`=1. It is a combinational output.
- R9: In a command that both multiplies and loads, the multiply uses the data-register contents from before that load.
- R10: A command is sampled on a rising edge with `cmd_valid`=1, and its result is visible after that edge. When `cmd_valid`=0 or `cmd_kind`=3, the accumulator holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_kind | input | 2 | 0 multiply, 1 multiply-add, 2 multiply-subtract, 3 no arithmetic |
| cmd_unsigned | input | 1 | Unsigned request for plain multiply of two general registers |
| a_from_dreg | input | 1 | Operand A from the A data bank |
| a_dsel | input | 1 | A bank entry (data register 0 or 1) |
| a_hi | input | 1 | Operand A uses the upper half |
| b_from_dreg | input | 1 | Operand B from the B data bank |
| b_dsel | input | 1 | B bank entry (data register 2 or 3) |
| b_hi | input | 1 | Operand B uses the upper half |
| gr_a | input | 32 | General-register value for operand A |
| gr_b | input | 32 | General-register value for operand B |
| ld_en | input | 1 | Load a data register this command |
| ld_down | input | 1 | Step the address down instead of up |
| ld_idx | input | 2 | Data register to load |
| addr_base | input | 32 | Base address before the step |
| mem_rdata | input | 32 | Memory word read at `ld_addr` |
| ld_addr | output | 32 | Stepped address for the access and write-back |
| acc_lo | output | 32 | Accumulator bits 31:0 |
| acc_hi | output | 8 | Accumulator bits 39:32 |

## Verification
The bench builds the block with its default parameters: 16-bit operands, 32-bit sources, a 40-bit accumulator, four data registers and a 4-byte step. With these values the largest signed product is 2^30, so 1024 accumulations of that product carry the accumulator across 2^40 and back to zero. The bench uses that sequence to reach the wrap boundary and to pass through the sign flip at 2^39. The two-entry banks keep every source path small enough to check directly: each data register is loaded with a distinct word and then read back through the multiplier. The bench also covers the cases where the unsigned request must be ignored and a compound command where the load and the multiply act on the same register.

// File: rtl/mac16_pkg.sv
package mac16_pkg;

    localparam int OP_W   = 16;
    localparam int SRC_W  = 32;
    localparam int ACC_W  = 40;
    localparam int DREG_N = 4;
    localparam int ADDR_W = 32;
    localparam int STEP   = 4;

    typedef enum logic [1:0] {
        K_MUL  = 2'd0,
        K_MULA = 2'd1,
        K_MULS = 2'd2,
        K_NONE = 2'd3
    } mac_kind_e;

    typedef struct packed {
        mac_kind_e kind;
        logic      want_uns;
        logic      both_gen;
    } arith_ctl_t;

    function automatic logic uns_effective(arith_ctl_t c);
        return c.want_uns && c.both_gen && (c.kind == K_MUL);
    endfunction

endpackage

// File: rtl/mac_opnd_mux.sv
module mac_opnd_mux #(
    parameter int OP_W   = 16,
    parameter int SRC_W  = 32,
    parameter int HALF_N = 2,
    parameter int DSEL_W = 1
) (
    input  logic [SRC_W-1:0]             gr,
    input  logic [HALF_N-1:0][SRC_W-1:0] bank,
    input  logic                         from_dreg,
    input  logic [DSEL_W-1:0]            dsel,
    input  logic                         hi,
    output logic [OP_W-1:0]              opnd
);
    logic [SRC_W-1:0] src;

    always_comb begin
        src  = from_dreg ? bank[dsel] : gr;
        opnd = hi ? src[SRC_W-1 -: OP_W] : src[OP_W-1:0];
    end
endmodule

// File: rtl/mac_mul_acc.sv
module mac_mul_acc
    import mac16_pkg::*;
#(
    parameter int OP_W  = 16,
    parameter int ACC_W = 40
) (
    input  arith_ctl_t       ctl,
    input  logic [OP_W-1:0]  opa,
    input  logic [OP_W-1:0]  opb,
    input  logic [ACC_W-1:0] acc_q,
    output logic [ACC_W-1:0] acc_d
);
    localparam int PROD_W = 2 * OP_W;
    localparam int EXT_W  = ACC_W - PROD_W;

    logic              use_uns;
    logic [PROD_W-1:0] prod_s;
    logic [PROD_W-1:0] prod_u;
    logic [ACC_W-1:0]  prod_ext;

    always_comb begin
        use_uns  = uns_effective(ctl);
        prod_s   = $signed({{OP_W{opa[OP_W-1]}}, opa}) * $signed({{OP_W{opb[OP_W-1]}}, opb});
        prod_u   = {{OP_W{1'b0}}, opa} * {{OP_W{1'b0}}, opb};
        prod_ext = use_uns ? {{EXT_W{1'b0}}, prod_u}
                           : {{EXT_W{prod_s[PROD_W-1]}}, prod_s};
        unique case (ctl.kind)
            K_MUL:   acc_d = prod_ext;
            K_MULA:  acc_d = acc_q + prod_ext;
            K_MULS:  acc_d = acc_q - prod_ext;
            default: acc_d = acc_q;
        endcase
    end
endmodule

// File: rtl/mac_addr_step.sv
module mac_addr_step #(
    parameter int ADDR_W = 32,
    parameter int STEP   = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic              down,
    output logic [ADDR_W-1:0] stepped
);
    localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

    always_comb stepped = down ? (base - STEP_V) : (base + STEP_V);
endmodule

// File: rtl/mac16_unit.sv
module mac16_unit
    import mac16_pkg::*;
#(
    parameter int OP_W   = mac16_pkg::OP_W,
    parameter int SRC_W  = mac16_pkg::SRC_W,
    parameter int ACC_W  = mac16_pkg::ACC_W,
    parameter int DREG_N = mac16_pkg::DREG_N,
    parameter int ADDR_W = mac16_pkg::ADDR_W,
    parameter int STEP   = mac16_pkg::STEP,
    localparam int HALF_N   = DREG_N / 2,
    localparam int DSEL_W   = (HALF_N > 1) ? $clog2(HALF_N) : 1,
    localparam int DIDX_W   = $clog2(DREG_N),
    localparam int ACC_HI_W = ACC_W - SRC_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_kind,
    input  logic                cmd_unsigned,
    input  logic                a_from_dreg,
    input  logic [DSEL_W-1:0]   a_dsel,
    input  logic                a_hi,
    input  logic                b_from_dreg,
    input  logic [DSEL_W-1:0]   b_dsel,
    input  logic                b_hi,
    input  logic [SRC_W-1:0]    gr_a,
    input  logic [SRC_W-1:0]    gr_b,
    input  logic                ld_en,
    input  logic                ld_down,
    input  logic [DIDX_W-1:0]   ld_idx,
    input  logic [ADDR_W-1:0]   addr_base,
    input  logic [SRC_W-1:0]    mem_rdata,
    output logic [ADDR_W-1:0]   ld_addr,
    output logic [SRC_W-1:0]    acc_lo,
    output logic [ACC_HI_W-1:0] acc_hi
);
    logic [SRC_W-1:0]             dreg_q [DREG_N];
    logic [HALF_N-1:0][SRC_W-1:0] bank_a;
    logic [HALF_N-1:0][SRC_W-1:0] bank_b;
    logic [OP_W-1:0]              opa;
    logic [OP_W-1:0]              opb;
    logic [ACC_W-1:0]             acc_q;
    logic [ACC_W-1:0]             acc_d;
    arith_ctl_t                   ctl;

    // data registers: bank A is the lower half, bank B the upper half
    for (genvar g = 0; g < DREG_N; g++) begin : g_dreg
        always_ff @(posedge clk) begin
            if (rst)
                dreg_q[g] <= '0;
            else if (cmd_valid && ld_en && (ld_idx == DIDX_W'(g)))
                dreg_q[g] <= mem_rdata;
        end
    end

    for (genvar h = 0; h < HALF_N; h++) begin : g_bank
        assign bank_a[h] = dreg_q[h];
        assign bank_b[h] = dreg_q[HALF_N + h];
    end

    mac_opnd_mux #(.OP_W(OP_W), .SRC_W(SRC_W), .HALF_N(HALF_N), .DSEL_W(DSEL_W)) u_mux_a (
        .gr(gr_a), .bank(bank_a), .from_dreg(a_from_dreg), .dsel(a_dsel), .hi(a_hi), .opnd(opa)
    );

    mac_opnd_mux #(.OP_W(OP_W), .SRC_W(SRC_W), .HALF_N(HALF_N), .DSEL_W(DSEL_W)) u_mux_b (
        .gr(gr_b), .bank(bank_b), .from_dreg(b_from_dreg), .dsel(b_dsel), .hi(b_hi), .opnd(opb)
    );

    always_comb begin
        ctl.kind     = mac_kind_e'(cmd_kind);
        ctl.want_uns = cmd_unsigned;
        ctl.both_gen = !a_from_dreg && !b_from_dreg;
    end

    mac_mul_acc #(.OP_W(OP_W), .ACC_W(ACC_W)) u_arith (
        .ctl(ctl), .opa(opa), .opb(opb), .acc_q(acc_q), .acc_d(acc_d)
    );

    mac_addr_step #(.ADDR_W(ADDR_W), .STEP(STEP)) u_step (
        .base(addr_base), .down(ld_down), .stepped(ld_addr)
    );

    always_ff @(posedge clk) begin
        if (rst)
            acc_q <= '0;
        else if (cmd_valid)
            acc_q <= acc_d;
    end

    assign acc_lo = acc_q[SRC_W-1:0];
    assign acc_hi = acc_q[ACC_W-1:SRC_W];
endmodule

// File: rtl/mac16_chk.sv
module mac16_chk #(
    parameter int OP_W   = 16,
    parameter int SRC_W  = 32,
    parameter int ACC_W  = 40,
    parameter int ADDR_W = 32,
    localparam int ACC_HI_W = ACC_W - SRC_W
) (
    input logic                clk,
    input logic                rst,
    input logic                cmd_valid,
    input logic [1:0]          cmd_kind,
    input logic                a_from_dreg,
    input logic                a_hi,
    input logic [SRC_W-1:0]    gr_a,
    input logic                ld_en,
    input logic [ADDR_W-1:0]   addr_base,
    input logic [ADDR_W-1:0]   ld_addr,
    input logic [SRC_W-1:0]    acc_lo,
    input logic [ACC_HI_W-1:0] acc_hi
);
    logic [ACC_W-1:0] acc_v;
    logic [OP_W-1:0]  ga_half;
    assign acc_v   = {acc_hi, acc_lo};
    assign ga_half = a_hi ? gr_a[SRC_W-1 -: OP_W] : gr_a[OP_W-1:0];

    // R1: reset leaves the accumulator at zero
    a_r1_reset_clears: assert property (@(posedge clk) rst |=> (acc_v == '0));

    // R10: an idle cycle keeps the accumulator
    a_r10_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> $stable(acc_v));

    // R10: a command without arithmetic keeps the accumulator
    a_r10_none_holds: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 2'd3) |=> $stable(acc_v));

    // R4: a zero operand gives a zero result for plain multiply
    a_r4_zero_product: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 2'd0 && !a_from_dreg && ga_half == '0) |=> (acc_v == '0));

    // R6: adding a zero product leaves the accumulator unchanged
    a_r6_add_zero: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_kind == 2'd1 && !a_from_dreg && ga_half == '0) |=> $stable(acc_v));

    // R8: the load address lies exactly one step away from the base
    a_r8_step_size: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && ld_en) |-> ((ld_addr - addr_base == ADDR_W'(4)) || (addr_base - ld_addr == ADDR_W'(4))));
endmodule

bind mac16_unit mac16_chk #(.OP_W(OP_W), .SRC_W(SRC_W), .ACC_W(ACC_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_mac16_unit.sv
module sim_mac16_unit;
    import mac16_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  kind;
        logic        uns;
        logic        ahi;
        logic        bhi;
        logic [31:0] ga;
        logic [31:0] gb;
        logic [39:0] exp;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t TBL [NVEC] = '{
        '{2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_0003, 32'h0000_0005, 40'h00_0000_000F},
        '{2'd1, 1'b0, 1'b0, 1'b0, 32'h0000_FFFF, 32'h0000_0002, 40'h00_0000_000D},
        '{2'd2, 1'b0, 1'b1, 1'b0, 32'h0004_0000, 32'h0000_0007, 40'hFF_FFFF_FFF1},
        '{2'd0, 1'b1, 1'b0, 1'b0, 32'h0000_FFFF, 32'h0000_FFFF, 40'h00_FFFE_0001},
        '{2'd0, 1'b0, 1'b0, 1'b0, 32'h0000_FFFF, 32'h0000_FFFF, 40'h00_0000_0001},
        '{2'd0, 1'b0, 1'b1, 1'b1, 32'h8000_0000, 32'h8000_1234, 40'h00_4000_0000},
        '{2'd1, 1'b0, 1'b0, 1'b0, 32'h0000_8000, 32'h0000_7FFF, 40'h00_0000_8000},
        '{2'd2, 1'b0, 1'b0, 1'b0, 32'h0000_8000, 32'h0000_8000, 40'hFF_C000_8000}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_kind = 2'd3;
    logic        cmd_unsigned = 1'b0;
    logic        a_from_dreg = 1'b0;
    logic        a_dsel = 1'b0;
    logic        a_hi = 1'b0;
    logic        b_from_dreg = 1'b0;
    logic        b_dsel = 1'b0;
    logic        b_hi = 1'b0;
    logic [31:0] gr_a = '0;
    logic [31:0] gr_b = '0;
    logic        ld_en = 1'b0;
    logic        ld_down = 1'b0;
    logic [1:0]  ld_idx = '0;
    logic [31:0] addr_base = '0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] ld_addr;
    logic [31:0] acc_lo;
    logic [7:0]  acc_hi;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    mac16_unit u0 (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_acc(input string req, input logic [39:0] exp);
        chk(req, {24'd0, acc_hi, acc_lo}, {24'd0, exp});
    endtask

    task automatic set_op(input logic [1:0] k, input logic u,
                          input logic afd, input logic ads, input logic ah,
                          input logic bfd, input logic bds, input logic bh,
                          input logic [31:0] ga, input logic [31:0] gb);
        cmd_kind = k; cmd_unsigned = u;
        a_from_dreg = afd; a_dsel = ads; a_hi = ah;
        b_from_dreg = bfd; b_dsel = bds; b_hi = bh;
        gr_a = ga; gr_b = gb;
        ld_en = 1'b0;
    endtask

    task automatic set_ld(input logic [1:0] idx, input logic down,
                          input logic [31:0] base, input logic [31:0] word);
        ld_en = 1'b1; ld_idx = idx; ld_down = down; addr_base = base; mem_rdata = word;
    endtask

    // issue the driven command on one edge, return at the following falling edge
    task automatic step();
        cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        ld_en = 1'b0;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk_acc("R1 reset value", 40'h0);

        // table walk: general-register operands, all kinds
        for (int i = 0; i < NVEC; i++) begin
            set_op(TBL[i].kind, TBL[i].uns, 1'b0, 1'b0, TBL[i].ahi,
                   1'b0, 1'b0, TBL[i].bhi, TBL[i].ga, TBL[i].gb);
            step();
            chk_acc($sformatf("R2/R4/R5/R6 vector %0d", i), TBL[i].exp);
        end

        // R10: valid low has no effect
        set_op(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h7, 32'h7);
        @(posedge clk);
        @(negedge clk);
        chk_acc("R10 idle hold", 40'hFF_C000_8000);

        // R8: loads with pre-step address; kind 3 leaves accumulator
        set_op(2'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h7, 32'h7);
        set_ld(2'd0, 1'b0, 32'h0000_1000, 32'h0003_FFFE);
        #1 chk("R8 increment address", {32'd0, ld_addr}, {32'd0, 32'h0000_1004});
        step();
        chk_acc("R10 kind none hold", 40'hFF_C000_8000);
        set_ld(2'd2, 1'b1, 32'h0000_1000, 32'h0005_0004);
        #1 chk("R8 decrement address", {32'd0, ld_addr}, {32'd0, 32'h0000_0FFC});
        step();
        set_ld(2'd1, 1'b0, 32'h0000_2000, 32'h0000_0007);
        step();
        set_ld(2'd3, 1'b1, 32'h0000_0000, 32'hFFFF_0002);
        #1 chk("R8 decrement wraps below zero", {32'd0, ld_addr}, {32'd0, 32'hFFFF_FFFC});
        step();

        // R3: data x data, dreg0 low (-2) times dreg2 high (5)
        set_op(2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 32'h0, 32'h0);
        step();
        chk_acc("R3/R8 dreg0 x dreg2", 40'hFF_FFFF_FFF6);

        // R5: unsigned request ignored when a data register is a source
        set_op(2'd0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0000_0003);
        step();
        chk_acc("R5 unsigned ignored for data source", 40'hFF_FFFF_FFFA);

        // R9: compound add while reloading dreg0; uses old dreg0 high (3) x dreg3 high (-1)
        set_op(2'd1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0, 32'h0);
        set_ld(2'd0, 1'b0, 32'h0000_1004, 32'h0000_0010);
        step();
        chk_acc("R9 compound uses old data", 40'hFF_FFFF_FFF7);

        set_op(2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0000_0002);
        step();
        chk_acc("R9 compound load landed", 40'h00_0000_0020);

        // R3: other bank entries
        set_op(2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0, 32'h0);
        step();
        chk_acc("R3 dreg1 x dreg3", 40'h00_0000_000E);
        set_op(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 32'h0000_0003, 32'h0);
        step();
        chk_acc("R3 general x dreg2", 40'h00_0000_000C);

        // R5: unsigned request ignored for multiply-add
        set_op(2'd1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_FFFF, 32'h0000_FFFF);
        step();
        chk_acc("R5 unsigned ignored for add", 40'h00_0000_000D);

        // R7: 1024 products of 2^30 wrap to zero
        set_op(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_8000, 32'h0000_8000);
        step();
        cmd_kind = 2'd1;
        for (int i = 1; i < 1024; i++) begin
            step();
            if (i == 511) chk_acc("R7 reaches 2^39", 40'h80_0000_0000);
        end
        chk_acc("R7 wraps modulo 2^40", 40'h00_0000_0000);

        // R1: reset mid-run clears accumulator and data registers
        set_op(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1, 32'h1);
        step();
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk_acc("R1 reset clears accumulator", 40'h0);
        set_op(2'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h1, 32'h1);
        step();
        set_op(2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0000_0005);
        step();
        chk_acc("R1 reset clears data registers", 40'h0);

        summary();
    end
endmodule